// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Compare

This block is a register-controlled 32-bit up-counter. Software loads the count, a reload value and a compare value, then starts it. The count advances on every clock, or once every 2^(k+1) clocks when the prescaler is on, where k is a 3-bit divider code. When the count passes its top value it either reloads and keeps running or stops at zero. A compare unit flags the tick that brings the count to the compare value.

Two events drive the block's outputs: wrap and match. Each has an interrupt enable, which lets it latch a write-one-to-clear status flag, and a wakeup enable, which makes it emit a one-clock wake pulse. One level interrupt line shows whether any flag is set. A single output pin can follow the events, either as a one-clock pulse away from a programmable idle level or as a toggle. It can also be frozen by declaring the pin an input.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and `pin_o`, `irq_o` and `wake_o` are low.
- R2: Registers are 32-bit words selected by `bus_addr[4:2]`: 0x00 control, 0x04 count, 0x08 reload value, 0x0C reload trigger, 0x10 compare value, 0x14 status, 0x18 interrupt enables, 0x1C wakeup enables. Control bits are: 0 run, 1 auto-reload, 4:2 divider code k, 5 prescaler enable, 6 compare enable, 7 idle level, 11:10 trigger select, 12 toggle mode, 14 pin is input. The other control bits and the reload trigger read as zero. Writes are taken when `bus_sel` and `bus_wr` are high, and reads return the addressed register with no delay.
- R3: With run set and the prescaler off, the count rises by one on each clock edge after the edge that wrote the control register. With run clear, the count holds.
- R4: With the prescaler on, the count advances once every 2^(k+1) clocks, counted from the last write to the control, count or reload-trigger register.
- R5: When the count wraps from 0xFFFFFFFF with auto-reload set, it takes the reload value and keeps running. This wrap is the overflow event.
- R6: When it wraps with auto-reload clear, the count becomes 0 and the run bit clears.
- R7: With compare enable set, a tick that makes the new count equal the compare value is the match event. This includes a wrap or reload result.
- R8: Status bit 0 (match) and bit 1 (overflow) are set by their event only when the same bit of the interrupt-enable register is set. Writing 1 to a status bit clears it, but a new event in the same cycle wins. `irq_o` is high while any status bit is set.
- R9: Each event whose wakeup-enable bit is set (bit 0 match, bit 1 overflow) gives `wake_o` high for exactly the following cycle. This happens whatever the interrupt enables are.
- R10: A write to the count register loads the written value. A write of any value to the reload trigger copies the reload value into the count. A write to the control, count or reload-trigger register takes precedence over a tick in that cycle.
- R11: Trigger select 1 puts the pin on overflow events only, 2 on overflow and match, and 0 or 3 on none. In toggle mode an event inverts `pin_o`. Otherwise an event drives the inverse of the idle level for one cycle.
- R12: With the pin set as input, `pin_o` holds its value. Otherwise, while stopped or with no trigger selected, `pin_o` is driven to the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pin_o | output | 1 | Event output pin |
| irq_o | output | 1 | Level interrupt, high while a status flag is set |
| wake_o | output | 1 | One-cycle wakeup pulse |

## Verification
The count is readable at all times, so an error in the prescaler phase or the counter shows on the read port within one divider period. An error in wrap handling shows at the first wrap, as a wrong reload value, a run bit that stays set, or a missing flag, wake pulse or pin edge in the cycle after the wrap tick. A stale status or pin state only appears when an event or a clear write touches it. For that reason the stimulus places clear writes and control changes on the exact cycle of a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PTV_W = 3;
  localparam int DIV_W = 1 << PTV_W;
  localparam int EVT_N = 2;
  localparam int EV_MAT = 0;
  localparam int EV_OVF = 1;

  localparam logic [2:0] RG_CTRL   = 3'd0;
  localparam logic [2:0] RG_COUNT  = 3'd1;
  localparam logic [2:0] RG_LOAD   = 3'd2;
  localparam logic [2:0] RG_RELOAD = 3'd3;
  localparam logic [2:0] RG_MATCH  = 3'd4;
  localparam logic [2:0] RG_STATUS = 3'd5;
  localparam logic [2:0] RG_IEN    = 3'd6;
  localparam logic [2:0] RG_WEN    = 3'd7;

  typedef enum logic [1:0] {
    TRG_NONE = 2'd0,
    TRG_OVF  = 2'd1,
    TRG_BOTH = 2'd2,
    TRG_RSVD = 2'd3
  } trig_e;

  typedef struct packed {
    logic             pin_in;
    logic             toggle;
    trig_e            trig;
    logic             dflt;
    logic             cmp_en;
    logic             pre_en;
    logic [PTV_W-1:0] ptv;
    logic             reload_en;
    logic             run;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [31:0] w);
    ctrl_t c;
    c.run       = w[0];
    c.reload_en = w[1];
    c.ptv       = w[4:2];
    c.pre_en    = w[5];
    c.cmp_en    = w[6];
    c.dflt      = w[7];
    c.trig      = trig_e'(w[11:10]);
    c.toggle    = w[12];
    c.pin_in    = w[14];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_encode(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[0]     = c.run;
    w[1]     = c.reload_en;
    w[4:2]   = c.ptv;
    w[5]     = c.pre_en;
    w[6]     = c.cmp_en;
    w[7]     = c.dflt;
    w[11:10] = c.trig;
    w[12]    = c.toggle;
    w[14]    = c.pin_in;
    return w;
  endfunction

  // last divider phase before a tick: 2^(p+1) - 1
  function automatic logic [DIV_W-1:0] div_limit(input logic [PTV_W-1:0] p);
    logic [DIV_W:0] span;
    span = (DIV_W+1)'(1) << (int'(p) + 1);
    return DIV_W'(span - 1'b1);
  endfunction

  function automatic logic trig_on_ovf(input trig_e t);
    return (t == TRG_OVF) || (t == TRG_BOTH);
  endfunction

  function automatic logic trig_on_mat(input trig_e t);
    return t == TRG_BOTH;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic             restart,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);

  logic [DIV_W-1:0] div_q;
  logic             at_lim;

  assign at_lim = (div_q == div_limit(ptv));
  assign tick   = run && !restart && (!pre_en || at_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || restart || !pre_en || at_lim) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_en) |-> !$past(tick));  // R4

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             set_wr,
  input  logic [CNT_W-1:0] set_val,
  input  logic             reload_wr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_hit,
  output logic             mat_hit
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] step;

  function automatic logic [CNT_W-1:0] after_tick(
    input logic [CNT_W-1:0] c, input logic wrap, input logic ar,
    input logic [CNT_W-1:0] ld);
    if (wrap) return ar ? ld : '0;
    return c + 1'b1;
  endfunction

  assign ovf_hit = tick && (cnt_q == TOP);
  assign step    = after_tick(cnt_q, ovf_hit, reload_en, load_val);
  assign mat_hit = tick && cmp_en && (step == match_val);
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (set_wr) begin
      cnt_q <= set_val;
    end else if (reload_wr) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= step;
    end
  end

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && reload_en) |=> (count == $past(load_val)));  // R5
  AST_ZERO_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !reload_en) |=> (count == '0));  // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !set_wr && !reload_wr) |=> $stable(count));  // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (count == $past(set_val)));  // R10

endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_in,
  input  logic  running,
  input  trig_e trig,
  input  logic  toggle,
  input  logic  dflt,
  input  logic  ovf_hit,
  input  logic  mat_hit,
  output logic  pin_o
);

  logic pin_q;
  logic pin_ev;
  logic active;

  assign pin_ev = (ovf_hit && trig_on_ovf(trig)) || (mat_hit && trig_on_mat(trig));
  assign active = running && trig_on_ovf(trig);
  assign pin_o  = pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (pin_in) begin
      pin_q <= pin_q;
    end else if (!active) begin
      pin_q <= dflt;
    end else if (toggle) begin
      pin_q <= pin_ev ? !pin_q : pin_q;
    end else begin
      pin_q <= pin_ev ? !dflt : dflt;
    end
  end

  AST_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pin_in |=> $stable(pin_o));  // R12
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_in && !active) |=> (pin_o == $past(dflt)));  // R12
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_in && active && toggle && pin_ev) |=> (pin_o != $past(pin_o)));  // R11

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt,
  input  logic [EVT_N-1:0] ien,
  input  logic [EVT_N-1:0] wen,
  input  logic             clr_wr,
  input  logic [EVT_N-1:0] clr_mask,
  output logic [EVT_N-1:0] flags,
  output logic             irq_o,
  output logic             wake_o
);

  logic [EVT_N-1:0] flags_q;
  logic             wake_q;
  logic [EVT_N-1:0] clr_bits;

  assign clr_bits = clr_wr ? clr_mask : '0;
  assign flags    = flags_q;
  assign irq_o    = |flags_q;
  assign wake_o   = wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_bits) | (evt & ien);
      wake_q  <= |(evt & wen);
    end
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[i]) |-> $past(ien[i]));  // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[i] && !(evt[i] && ien[i])) |=> !flags_q[i]);  // R8
  end

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & wen)) |=> wake_o);  // R9
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(|(evt & wen)));  // R9

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pin_o,
  output logic              irq_o,
  output logic              wake_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              wr_en;
  logic              wr_ctrl, wr_cnt, wr_load, wr_rld, wr_match, wr_stat, wr_ien, wr_wen;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] match_q;
  logic [EVT_N-1:0]  ien_q;
  logic [EVT_N-1:0]  wen_q;
  logic [DATA_W-1:0] count;
  logic [EVT_N-1:0]  flags;
  logic [EVT_N-1:0]  evt;
  logic              tick;
  logic              restart;
  logic              ovf_hit;
  logic              mat_hit;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign wr_en    = bus_sel && bus_wr;
  assign wr_ctrl  = wr_en && (idx == RG_CTRL);
  assign wr_cnt   = wr_en && (idx == RG_COUNT);
  assign wr_load  = wr_en && (idx == RG_LOAD);
  assign wr_rld   = wr_en && (idx == RG_RELOAD);
  assign wr_match = wr_en && (idx == RG_MATCH);
  assign wr_stat  = wr_en && (idx == RG_STATUS);
  assign wr_ien   = wr_en && (idx == RG_IEN);
  assign wr_wen   = wr_en && (idx == RG_WEN);
  assign restart  = wr_ctrl || wr_cnt || wr_rld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_decode(bus_wdata);
      end else if (ovf_hit && !ctrl_q.reload_en) begin
        ctrl_q.run <= 1'b0;
      end
      if (wr_load)  load_q  <= bus_wdata;
      if (wr_match) match_q <= bus_wdata;
      if (wr_ien)   ien_q   <= bus_wdata[EVT_N-1:0];
      if (wr_wen)   wen_q   <= bus_wdata[EVT_N-1:0];
    end
  end

  tmr_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .pre_en  (ctrl_q.pre_en),
    .restart (restart),
    .ptv     (ctrl_q.ptv),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reload_en (ctrl_q.reload_en),
    .cmp_en    (ctrl_q.cmp_en),
    .load_val  (load_q),
    .match_val (match_q),
    .set_wr    (wr_cnt),
    .set_val   (bus_wdata),
    .reload_wr (wr_rld),
    .count     (count),
    .ovf_hit   (ovf_hit),
    .mat_hit   (mat_hit)
  );

  assign evt[EV_MAT] = mat_hit;
  assign evt[EV_OVF] = ovf_hit;

  tmr_pin u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (ctrl_q.pin_in),
    .running (ctrl_q.run),
    .trig    (ctrl_q.trig),
    .toggle  (ctrl_q.toggle),
    .dflt    (ctrl_q.dflt),
    .ovf_hit (ovf_hit),
    .mat_hit (mat_hit),
    .pin_o   (pin_o)
  );

  tmr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .ien      (ien_q),
    .wen      (wen_q),
    .clr_wr   (wr_stat),
    .clr_mask (bus_wdata[EVT_N-1:0]),
    .flags    (flags),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (idx)
      RG_CTRL:   bus_rdata = DATA_W'(ctrl_encode(ctrl_q));
      RG_COUNT:  bus_rdata = count;
      RG_LOAD:   bus_rdata = load_q;
      RG_MATCH:  bus_rdata = match_q;
      RG_STATUS: bus_rdata = DATA_W'(flags);
      RG_IEN:    bus_rdata = DATA_W'(ien_q);
      RG_WEN:    bus_rdata = DATA_W'(wen_q);
      default:   bus_rdata = '0;
    endcase
  end

  AST_STOP_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !ctrl_q.reload_en && !wr_ctrl) |=> !ctrl_q.run);  // R6
  AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !ovf_hit && !mat_hit);  // R10

endmodule

// File: tb/tb_tick_cmp_timer.sv
module tb_tick_cmp_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_sel = 1'b0;
  logic        b_wr = 1'b0;
  logic [4:0]  b_addr = 5'h04;
  logic [31:0] b_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pin_o, irq_o, wake_o;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";

  tick_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .pin_o(pin_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  // behavioural reference state
  logic [31:0] m_cnt, m_load, m_match, m_nx;
  logic [1:0]  m_stat, m_ien, m_wen;
  logic        m_run, m_ar, m_pre, m_ce, m_dflt, m_tog, m_dir, m_pin, m_wake;
  int          m_ptv, m_trig, m_phase, m_period, m_sel;
  logic        w_any, wc, wn, wl, wt, wm, ws, wi, ww, tk, ov, mt, ev, act;

  function automatic logic [31:0] m_read(input int i);
    case (i)
      0: return {17'd0, m_dir, 1'b0, m_tog, 2'(m_trig), 2'b00, m_dflt, m_ce, m_pre, 3'(m_ptv), m_ar, m_run};
      1: return m_cnt;
      2: return m_load;
      4: return m_match;
      5: return {30'd0, m_stat};
      6: return {30'd0, m_ien};
      7: return {30'd0, m_wen};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", cur_req, what, act_v, exp_v, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_load = '0; m_match = '0; m_stat = '0; m_ien = '0; m_wen = '0;
      m_run = 0; m_ar = 0; m_pre = 0; m_ce = 0; m_dflt = 0; m_tog = 0; m_dir = 0;
      m_pin = 0; m_wake = 0; m_ptv = 0; m_trig = 0; m_phase = 0;
    end else begin
      w_any = b_sel && b_wr;
      m_sel = int'(b_addr[4:2]);
      wc = w_any && m_sel == 0; wn = w_any && m_sel == 1; wl = w_any && m_sel == 2;
      wt = w_any && m_sel == 3; wm = w_any && m_sel == 4; ws = w_any && m_sel == 5;
      wi = w_any && m_sel == 6; ww = w_any && m_sel == 7;
      m_period = m_pre ? (2 << m_ptv) : 1;
      tk = m_run && !(wc || wn || wt) && (m_phase == m_period - 1);
      ov = tk && (m_cnt == 32'hFFFF_FFFF);
      m_nx = ov ? (m_ar ? m_load : 32'd0) : m_cnt + 32'd1;
      mt = tk && m_ce && (m_nx == m_match);
      ev = (ov && (m_trig == 1 || m_trig == 2)) || (mt && m_trig == 2);
      act = m_run && (m_trig == 1 || m_trig == 2);
      if (!m_dir) begin
        if (!act) m_pin = m_dflt;
        else if (m_tog) m_pin = ev ? !m_pin : m_pin;
        else m_pin = ev ? !m_dflt : m_dflt;
      end
      m_wake = (ov && m_wen[1]) || (mt && m_wen[0]);
      if (ws) m_stat = m_stat & ~b_wdata[1:0];
      if (ov && m_ien[1]) m_stat[1] = 1'b1;
      if (mt && m_ien[0]) m_stat[0] = 1'b1;
      if (!m_run || wc || wn || wt || tk) m_phase = 0;
      else m_phase = m_phase + 1;
      if (wn) m_cnt = b_wdata;
      else if (wt) m_cnt = m_load;
      else if (tk) m_cnt = m_nx;
      if (ov && !m_ar) m_run = 0;
      if (wl) m_load = b_wdata;
      if (wm) m_match = b_wdata;
      if (wi) m_ien = b_wdata[1:0];
      if (ww) m_wen = b_wdata[1:0];
      if (wc) begin
        m_run = b_wdata[0]; m_ar = b_wdata[1]; m_ptv = int'(b_wdata[4:2]);
        m_pre = b_wdata[5]; m_ce = b_wdata[6]; m_dflt = b_wdata[7];
        m_trig = int'(b_wdata[11:10]); m_tog = b_wdata[12]; m_dir = b_wdata[14];
      end
    end
    #(CLK_PERIOD/4);
    chk("rdata", bus_rdata, m_read(int'(b_addr[4:2])));
    chk("pin_o", {31'd0, pin_o}, {31'd0, m_pin});
    chk("irq_o", {31'd0, irq_o}, {31'd0, |m_stat});
    chk("wake_o", {31'd0, wake_o}, {31'd0, m_wake});
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    b_sel = 1'b1; b_wr = 1'b1; b_addr = a; b_wdata = d;
  endtask

  task automatic idle(input int n, input logic [4:0] a);
    @(negedge clk);
    b_sel = 1'b1; b_wr = 1'b0; b_addr = a; b_wdata = '0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset values
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3, 5'h04);
    idle(2, 5'h00);
    idle(2, 5'h14);
    // R2: control layout read-back, unused bits and reload trigger read zero
    cur_req = "R2";
    wr(5'h00, 32'hFFFF_FFFF);
    idle(3, 5'h00);
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h1234_5678);
    idle(2, 5'h0C);
    idle(2, 5'h08);
    // R3: one step per clock, hold when stopped
    cur_req = "R3";
    wr(5'h04, 32'd100);
    wr(5'h00, 32'h1);
    idle(8, 5'h04);
    wr(5'h00, 32'h0);
    idle(4, 5'h04);
    // R4: prescaler periods 4, 2 and 256
    cur_req = "R4";
    wr(5'h00, 32'h25);
    idle(21, 5'h04);
    wr(5'h00, 32'h21);
    idle(9, 5'h04);
    wr(5'h00, 32'h3D);
    idle(530, 5'h04);
    wr(5'h00, 32'h0);
    // R5: wrap with reload, toggle pin on overflow, flags and wake
    cur_req = "R5";
    wr(5'h08, 32'd5);
    wr(5'h18, 32'h3);
    wr(5'h1C, 32'h3);
    wr(5'h04, 32'hFFFF_FFFC);
    wr(5'h00, 32'h1403);
    idle(12, 5'h04);
    cur_req = "R8";
    wr(5'h14, 32'h2);
    idle(2, 5'h14);
    wr(5'h00, 32'h0);
    idle(2, 5'h04);
    // R6 / R7: stop on wrap, match on the zero result, pulse pin with idle level 1
    cur_req = "R6";
    wr(5'h10, 32'h0);
    wr(5'h04, 32'hFFFF_FFFE);
    wr(5'h00, 32'h08C1);
    idle(6, 5'h00);
    idle(2, 5'h14);
    wr(5'h14, 32'h3);
    // R7: match mid-count, both-event trigger in pulse mode
    cur_req = "R7";
    wr(5'h10, 32'd20);
    wr(5'h04, 32'd10);
    wr(5'h00, 32'h0841);
    idle(15, 5'h14);
    wr(5'h14, 32'h1);
    wr(5'h00, 32'h0);
    // R9: wake without interrupt enables
    cur_req = "R9";
    wr(5'h18, 32'h0);
    wr(5'h04, 32'hFFFF_FFFD);
    wr(5'h00, 32'h3);
    idle(6, 5'h14);
    wr(5'h00, 32'h0);
    // R8: clear write in the same cycle as a new overflow: the set wins
    cur_req = "R8";
    wr(5'h18, 32'h3);
    wr(5'h04, 32'hFFFF_FFFE);
    wr(5'h00, 32'h3);
    wr(5'h08, 32'd7);
    wr(5'h14, 32'h3);
    idle(3, 5'h14);
    wr(5'h14, 32'h3);
    // R10: reload trigger while running and count write precedence
    cur_req = "R10";
    wr(5'h08, 32'd42);
    wr(5'h0C, 32'hDEAD_BEEF);
    idle(3, 5'h04);
    wr(5'h04, 32'd1000);
    idle(3, 5'h04);
    wr(5'h00, 32'h0);
    // R11: reserved trigger select acts as none; toggle on overflow and match
    cur_req = "R11";
    wr(5'h04, 32'hFFFF_FFFD);
    wr(5'h00, 32'h0C83);
    idle(6, 5'h04);
    wr(5'h10, 32'd3);
    wr(5'h04, 32'd0);
    wr(5'h00, 32'h1843);
    idle(8, 5'h04);
    // R12: stop drives idle level; input direction freezes the pin
    cur_req = "R12";
    wr(5'h00, 32'h0080);
    idle(3, 5'h00);
    wr(5'h00, 32'h4000);
    idle(4, 5'h00);
    wr(5'h00, 32'h0);
    idle(3, 5'h00);
    summary();
    $finish;
  end

endmodule